// File: doc/BRIEF.md
# Resynced Sync Window Generator

This block rebuilds video timing inside the pixel clock domain. A horizontal pixel counter and a vertical line counter restart on a chosen edge of an external reference sync. A 4-bit control picks the reference inputs and their edges. Every programmed horizontal position is therefore a distance in pixels from the chosen horizontal reference edge. Every vertical position is a distance in lines from the chosen vertical reference edge.

Three set/reset windows are built from the counters and the programmed compare values:

- a clamp pulse, compared against the pixel counter;
- a horizontal enable, compared against the pixel counter;
- a vertical enable, compared against the line counter.

The horizontal and vertical enables combine into the enable window that marks the active video area. A window whose set value is larger than its reset value wraps cleanly across the counter restart. The block also generates its own hsync and vsync.

Each counter has a tracker state machine with three states:

- SEEK: the state after reset, before any reference edge.
- LOCK: a reference edge has been seen.
- LOST: the counter saturated without a new edge.

The trackers move between these states by four transitions:

- SEEK to LOCK on the first detected edge.
- LOCK to LOCK on each later edge.
- LOCK to LOST when the counter reaches all-ones.
- LOST to LOCK when a new edge arrives.

While either tracker is out of LOCK, the block raises an invalid flag and forces the outputs that depend on it low. The clamp and the vertical enable keep running while the flag is high.

Top module: `sync_window_gen`

## Requirements
- R1: `ref_ctrl` selects the references. Bit 0 picks the horizontal source (0 = `href0`, 1 = `href1`). Bit 1 picks the horizontal edge (0 = rising, 1 = falling). Bit 2 picks the vertical source (0 = `vref0`, 1 = `vref1`). Bit 3 picks the vertical edge (0 = rising, 1 = falling). The unselected inputs have no effect on any output.
- R2: Suppose the first clock edge that samples a selected horizontal reference edge is edge n. The pixel position is then 0 after edge n+3 and rises by one on every later clock. An output keyed to position p changes at edge n+4+p.
- R3: The line counter rises by one on each horizontal restart. It becomes 0 on a vertical reference edge, with the same three-clock latency as R2. A vertical restart wins over a horizontal increment in the same cycle.
- R4: `clamp_o` rises one clock after the pixel position equals `clamp_set`. It falls one clock after the position equals `clamp_rst`. When both compares match, the reset compare wins.
- R5: `henab_o` follows the same set/reset rule with `hen_set` and `hen_rst`. It is forced low while `ref_invalid_o` is high.
- R6: `venab_o` applies the set/reset rule to the line count with `ven_set` and `ven_rst`. It is evaluated only in the clock after the pixel position is 0, so it changes only at line starts.
- R7: When a set value is greater than its reset value, the window turns on at set and stays high across the counter restart until the reset value is reached.
- R8: `enab_o` is high exactly when `henab_o` and `venab_o` are both high.
- R9: A counter that sees no reference edge stops at all-ones and its tracker enters LOST. `ref_invalid_o` is high whenever either tracker is in SEEK or LOST. While it is high, `hsync_o`, `vsync_o`, `henab_o` and `enab_o` are low, and `clamp_o` and `venab_o` still follow R4 and R6. A new edge returns the tracker to LOCK.
- R10: `hsync_o` is high while the pixel position is below `HSYNC_LEN`. `vsync_o` is high while the line count is below `VSYNC_LEN`. Both follow the one-clock output delay.
- R11: During and right after reset, all outputs are low except `ref_invalid_o`, which is high. Both counters start at all-ones in SEEK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| href0 | input | 1 | Horizontal reference candidate 0 |
| href1 | input | 1 | Horizontal reference candidate 1 |
| vref0 | input | 1 | Vertical reference candidate 0 |
| vref1 | input | 1 | Vertical reference candidate 1 |
| ref_ctrl | input | 4 | Reference source and edge selection |
| clamp_set | input | HW | Clamp set position |
| clamp_rst | input | HW | Clamp reset position |
| hen_set | input | HW | Horizontal enable set position |
| hen_rst | input | HW | Horizontal enable reset position |
| ven_set | input | VW | Vertical enable set line |
| ven_rst | input | VW | Vertical enable reset line |
| hsync_o | output | 1 | Generated horizontal sync |
| vsync_o | output | 1 | Generated vertical sync |
| henab_o | output | 1 | Horizontal enable |
| venab_o | output | 1 | Vertical enable |
| enab_o | output | 1 | Active video window |
| clamp_o | output | 1 | Clamp pulse |
| ref_invalid_o | output | 1 | A reference is absent or not yet seen |

## Verification
On every cycle, the assertions check three properties:

- Each window changes only after its own set or reset compare, and the vertical enable only at a line start.
- A locked tracker never holds a saturated counter.
- A saturated counter stays put until a reference edge, and each edge restarts the count in LOCK.

The bench scenarios cover what a single-cycle property cannot express. They check the exact latency from a reference edge to each output, and the rejection of unselected sources switching under falling-edge mode. They also cover windows that wrap across the line and frame restart, and recovery from lost horizontal and vertical references after saturation.

// File: rtl/swg_pkg.sv
package swg_pkg;

    typedef enum logic [1:0] {
        TRK_SEEK = 2'd0,
        TRK_LOCK = 2'd1,
        TRK_LOST = 2'd2
    } trk_state_e;

endpackage

// File: rtl/swg_ref_track.sv
module swg_ref_track
    import swg_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ref_a,
    input  logic         ref_b,
    input  logic         sel,
    input  logic         fall,
    input  logic         adv,
    output logic [W-1:0] cnt_o,
    output logic         load_o,
    output logic         locked_o
);

    localparam logic [W-1:0] CMAX = '1;
    localparam int SYNC_D = 3;

    logic              lvl;
    logic [SYNC_D-1:0] sh_q;
    logic              edge_det;
    logic              edge_q;
    logic [W-1:0]      cnt_q;
    logic [W-1:0]      cnt_nxt;
    trk_state_e        st_q;
    trk_state_e        st_nxt;

    // source select and polarity before the synchroniser
    assign lvl = (sel ? ref_b : ref_a) ^ fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            edge_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[SYNC_D-2:0], lvl};
            edge_q <= edge_det;
        end
    end

    assign edge_det = sh_q[1] & ~sh_q[2];

    always_comb begin
        if (edge_q) begin
            cnt_nxt = '0;
        end else if (adv && (cnt_q != CMAX)) begin
            cnt_nxt = cnt_q + 1'b1;
        end else begin
            cnt_nxt = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CMAX;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TRK_SEEK;
        end else begin
            st_q <= st_nxt;
        end
    end

    // next state
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            TRK_SEEK: begin
                if (edge_q) st_nxt = TRK_LOCK;
            end
            TRK_LOCK: begin
                if (!edge_q && (cnt_nxt == CMAX)) st_nxt = TRK_LOST;
            end
            TRK_LOST: begin
                if (edge_q) st_nxt = TRK_LOCK;
            end
            default: st_nxt = TRK_SEEK;
        endcase
    end

    assign cnt_o    = cnt_q;
    assign load_o   = edge_q;
    assign locked_o = (st_q == TRK_LOCK);

    // R9
    lock_not_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TRK_LOCK) |-> (cnt_q != CMAX));

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == CMAX) && !edge_q) |=> (cnt_q == CMAX));

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_q |=> ((cnt_q == '0) && (st_q == TRK_LOCK)));

endmodule

// File: rtl/swg_window.sv
module swg_window #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] rst_v,
    output logic         win_o
);

    logic win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= 1'b0;
        end else if (upd) begin
            if (cnt == rst_v) begin
                win_q <= 1'b0;
            end else if (cnt == set_v) begin
                win_q <= 1'b1;
            end
        end
    end

    assign win_o = win_q;

    // R6
    win_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(win_q) |-> $past(upd));

    // R4
    win_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_q) |-> ($past(cnt == set_v) && $past(cnt != rst_v)));

    // R7
    win_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(win_q) |-> $past(cnt == rst_v));

endmodule

// File: rtl/sync_window_gen.sv
module sync_window_gen #(
    parameter int HW        = 12,
    parameter int VW        = 11,
    parameter int HSYNC_LEN = 8,
    parameter int VSYNC_LEN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          href0,
    input  logic          href1,
    input  logic          vref0,
    input  logic          vref1,
    input  logic [3:0]    ref_ctrl,
    input  logic [HW-1:0] clamp_set,
    input  logic [HW-1:0] clamp_rst,
    input  logic [HW-1:0] hen_set,
    input  logic [HW-1:0] hen_rst,
    input  logic [VW-1:0] ven_set,
    input  logic [VW-1:0] ven_rst,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          henab_o,
    output logic          venab_o,
    output logic          enab_o,
    output logic          clamp_o,
    output logic          ref_invalid_o
);

    localparam logic [HW-1:0] HS_LEN = HW'(HSYNC_LEN);
    localparam logic [VW-1:0] VS_LEN = VW'(VSYNC_LEN);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          h_load;
    logic          v_load;
    logic          h_locked;
    logic          v_locked;
    logic          line_start;
    logic          clamp_w;
    logic          hen_w;
    logic          ven_w;
    logic          hs_q;
    logic          vs_q;
    logic          valid;

    swg_ref_track #(.W(HW)) u_htrk (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_a    (href0),
        .ref_b    (href1),
        .sel      (ref_ctrl[0]),
        .fall     (ref_ctrl[1]),
        .adv      (1'b1),
        .cnt_o    (hcnt),
        .load_o   (h_load),
        .locked_o (h_locked)
    );

    swg_ref_track #(.W(VW)) u_vtrk (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_a    (vref0),
        .ref_b    (vref1),
        .sel      (ref_ctrl[2]),
        .fall     (ref_ctrl[3]),
        .adv      (h_load),
        .cnt_o    (vcnt),
        .load_o   (v_load),
        .locked_o (v_locked)
    );

    assign line_start = (hcnt == '0);

    swg_window #(.W(HW)) u_clamp (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (1'b1),
        .cnt   (hcnt),
        .set_v (clamp_set),
        .rst_v (clamp_rst),
        .win_o (clamp_w)
    );

    swg_window #(.W(HW)) u_hen (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (1'b1),
        .cnt   (hcnt),
        .set_v (hen_set),
        .rst_v (hen_rst),
        .win_o (hen_w)
    );

    swg_window #(.W(VW)) u_ven (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (line_start),
        .cnt   (vcnt),
        .set_v (ven_set),
        .rst_v (ven_rst),
        .win_o (ven_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            hs_q <= (hcnt < HS_LEN);
            vs_q <= (vcnt < VS_LEN);
        end
    end

    assign valid         = h_locked & v_locked;
    assign hsync_o       = hs_q & valid;
    assign vsync_o       = vs_q & valid;
    assign henab_o       = hen_w & valid;
    assign venab_o       = ven_w;
    assign enab_o        = hen_w & ven_w & valid;
    assign clamp_o       = clamp_w;
    assign ref_invalid_o = ~valid;

    // R3
    vcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_load && !v_load) |=> $stable(vcnt));

endmodule

// File: tb/sync_window_gen_tb_top.sv
module sync_window_gen_tb_top;

    localparam int HW = 8;
    localparam int VW = 5;
    localparam int HMAX = 255;
    localparam int VMAX = 31;
    localparam int LINE = 40;
    localparam int FRAME_LINES = 8;

    typedef struct {
        logic hs;
        logic vs;
        logic he;
        logic ve;
        logic en;
        logic cl;
        logic inv;
        string ph;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic href0 = 1'b0, href1 = 1'b0, vref0 = 1'b0, vref1 = 1'b0;
    logic [3:0] ref_ctrl = 4'b0000;
    logic [HW-1:0] clamp_set = 8'd2, clamp_rst = 8'd5;
    logic [HW-1:0] hen_set = 8'd8, hen_rst = 8'd30;
    logic [VW-1:0] ven_set = 5'd2, ven_rst = 5'd6;
    logic hsync_o, vsync_o, henab_o, venab_o, enab_o, clamp_o, ref_invalid_o;

    int checks = 0;
    int failures = 0;
    exp_t sb_q[$];
    string phase = "R11";

    // stimulus controls
    logic gen_h = 1'b0, gen_v = 1'b0, pol_h = 1'b0, pol_v = 1'b0, alt = 1'b0;
    int hph = 0, lph = 0, nzc = 0;

    always #5 clk = ~clk;

    sync_window_gen #(.HW(HW), .VW(VW), .HSYNC_LEN(4), .VSYNC_LEN(2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .href0(href0), .href1(href1), .vref0(vref0), .vref1(vref1),
        .ref_ctrl(ref_ctrl),
        .clamp_set(clamp_set), .clamp_rst(clamp_rst),
        .hen_set(hen_set), .hen_rst(hen_rst),
        .ven_set(ven_set), .ven_rst(ven_rst),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .henab_o(henab_o),
        .venab_o(venab_o), .enab_o(enab_o), .clamp_o(clamp_o),
        .ref_invalid_o(ref_invalid_o)
    );

    // reference pattern generator, drives on falling clock edge
    always @(negedge clk) begin
        logic hp, vp, nz, ha, va;
        if (gen_h) begin
            hph = (hph + 1) % LINE;
            if (hph == 0) lph = (lph + 1) % FRAME_LINES;
        end
        nzc = nzc + 1;
        nz = ((nzc / 7) % 2) == 1;
        hp = gen_h && (hph < 5);
        vp = gen_v && (lph == 0);
        ha = hp ^ pol_h;
        va = vp ^ pol_v;
        if (alt) begin
            href1 <= ha; vref1 <= va; href0 <= nz; vref0 <= ~nz;
        end else begin
            href0 <= ha; vref0 <= va; href1 <= nz; vref1 <= ~nz;
        end
    end

    // driver-side reference model: pushes the expected outputs after each edge
    int m_hc = HMAX, m_vc = VMAX, m_hst = 0, m_vst = 0;
    logic m_hlp = 0, m_vlp = 0;
    logic [2:0] m_hd = '0, m_vd = '0;
    logic m_cl = 0, m_he = 0, m_ve = 0, m_hs = 0, m_vs = 0;

    always @(posedge clk) begin
        logic hl, vl, hnow, vnow, hload, vload, ok;
        exp_t e;
        if (!rst_n) begin
            m_hc = HMAX; m_vc = VMAX; m_hst = 0; m_vst = 0;
            m_hlp = 0; m_vlp = 0; m_hd = '0; m_vd = '0;
            m_cl = 0; m_he = 0; m_ve = 0; m_hs = 0; m_vs = 0;
        end else begin
            // R4 R5 R6 R10: outputs from the counts before this edge
            m_cl = (m_hc == clamp_rst) ? 1'b0 : (m_hc == clamp_set) ? 1'b1 : m_cl;
            m_he = (m_hc == hen_rst) ? 1'b0 : (m_hc == hen_set) ? 1'b1 : m_he;
            if (m_hc == 0)
                m_ve = (m_vc == ven_rst) ? 1'b0 : (m_vc == ven_set) ? 1'b1 : m_ve;
            m_hs = (m_hc < 4);
            m_vs = (m_vc < 2);
            // R1 R2 R3: edge detection and restart latency
            hl = (ref_ctrl[0] ? href1 : href0) ^ ref_ctrl[1];
            vl = (ref_ctrl[2] ? vref1 : vref0) ^ ref_ctrl[3];
            hnow = hl & ~m_hlp; m_hlp = hl;
            vnow = vl & ~m_vlp; m_vlp = vl;
            hload = m_hd[2]; m_hd = {m_hd[1:0], hnow};
            vload = m_vd[2]; m_vd = {m_vd[1:0], vnow};
            if (hload) m_hc = 0; else if (m_hc != HMAX) m_hc = m_hc + 1;
            if (vload) m_vc = 0; else if (hload && m_vc != VMAX) m_vc = m_vc + 1;
            // R9 tracker states
            if (hload) m_hst = 1; else if (m_hst == 1 && m_hc == HMAX) m_hst = 2;
            if (vload) m_vst = 1; else if (m_vst == 1 && m_vc == VMAX) m_vst = 2;
            ok = (m_hst == 1) && (m_vst == 1);
            e.hs = m_hs & ok; e.vs = m_vs & ok; e.he = m_he & ok;
            e.ve = m_ve; e.en = m_he & m_ve & ok; e.cl = m_cl; e.inv = ~ok;
            e.ph = phase;
            sb_q.push_back(e);
        end
    end

    task automatic check_bit(input string tag, input string ph, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s (phase %s) t=%0t actual=%b expected=%b", tag, ph, $time, act, exp);
        end
    endtask

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check_bit("R10 hsync", e.ph, hsync_o, e.hs);
            check_bit("R10 vsync", e.ph, vsync_o, e.vs);
            check_bit("R5 henab", e.ph, henab_o, e.he);
            check_bit("R6 venab", e.ph, venab_o, e.ve);
            check_bit("R8 enab", e.ph, enab_o, e.en);
            check_bit("R4 clamp", e.ph, clamp_o, e.cl);
            check_bit("R9 invalid", e.ph, ref_invalid_o, e.inv);
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(4);
        // R11 reset state
        check_bit("R11 hsync", "R11", hsync_o, 1'b0);
        check_bit("R11 enab", "R11", enab_o, 1'b0);
        check_bit("R11 clamp", "R11", clamp_o, 1'b0);
        check_bit("R11 venab", "R11", venab_o, 1'b0);
        check_bit("R11 invalid", "R11", ref_invalid_o, 1'b1);
        rst_n = 1'b1;
        run(3);
        // R11 just after reset, no reference yet
        check_bit("R11 invalid", "R11", ref_invalid_o, 1'b1);
        check_bit("R11 henab", "R11", henab_o, 1'b0);
        // R2 R3: rising edges on source 0
        phase = "R2";
        gen_h = 1'b1; gen_v = 1'b1;
        run(900);
        // R1: falling edges on source 1, source 0 toggles as noise
        phase = "R1";
        alt = 1'b1; pol_h = 1'b1; pol_v = 1'b1; ref_ctrl = 4'b1111;
        run(900);
        // R7: wraparound windows
        phase = "R7";
        hen_set = 8'd30; hen_rst = 8'd8;
        ven_set = 5'd6; ven_rst = 5'd2;
        clamp_set = 8'd36; clamp_rst = 8'd3;
        run(900);
        // R9: horizontal reference lost, then recovered
        phase = "R9";
        gen_h = 1'b0;
        run(400);
        phase = "R3";
        gen_h = 1'b1;
        run(800);
        // R9: vertical reference lost, then recovered
        phase = "R9";
        gen_v = 1'b0;
        run(1500);
        phase = "R6";
        gen_v = 1'b1;
        run(800);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule